// File: doc/BRIEF.md
# Multi-Mode PWM Time-Base Counter

This block is the time base that sits in front of PWM comparators. An 8-bit prescaler divides the input clock, and each resulting tick moves a 16-bit counter. The counter runs in one of three modes against a programmable period: it can ramp up, ramp down, or rise and fall in a triangle. Downstream logic compares the counter value against its own thresholds. It uses the zero and period strobes to mark cycle boundaries.

The period and mode inputs act as shadow values. The counter copies them into its working copy only while it sits at zero, so a change made mid-cycle never shortens or stretches the cycle in progress. A one-cycle sync pulse loads a phase value straight into the counter. This lets several time bases be aligned. The pulse can come from a hardware source or be generated by software. A run input starts and freezes counting.

Top module: `pwm_timebase`

## Requirements
- R1: While run is high, the counter moves once every prescale+1 clock cycles. The divider restarts from zero whenever run is low or a sync pulse arrives.
- R2: With mode code 0 (code 3 behaves the same), the counter steps 0, 1, …, period and then wraps to 0. That gives period+1 ticks per cycle, with dir_down low.
- R3: With mode code 1, a tick taken at 0 loads period, and each following tick decrements down to 0. That gives period+1 ticks per cycle, with dir_down high.
- R4: With mode code 2, the counter rises from 0 to period and then falls back to 0, giving 2×period ticks per cycle. dir_down goes high on the tick that leaves period, and goes low on the tick that leaves 0.
- R5: With a period of 0 in mode 0, the counter stays at 0 on every tick.
- R6: The period and mode used for counting are taken from period_in and mode_in only while the counter is 0. Changes made at other counter values have no effect until the counter next reaches 0.
- R7: A high sync on a clock edge loads phase into the counter. This takes priority over a tick, and it happens whether the counter is running or stopped.
- R8: A sync leaves dir_down unchanged.
- R9: zero_evt is high for exactly one clock after a tick that leaves the counter at 0. period_evt is high for exactly one clock after a tick that leaves the counter equal to the period in use.
- R10: While run is low and no sync arrives, the counter holds its value and both strobes stay low.
- R11: While rst_n is low, count is 0, dir_down is low and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | High to count, low to freeze |
| prescale | input | 8 | Clock divider minus one |
| period_in | input | 16 | Shadow period value |
| mode_in | input | 2 | Shadow mode: 0 up, 1 down, 2 up-down, 3 up |
| sync | input | 1 | Phase load pulse |
| phase | input | 16 | Value loaded on sync |
| count | output | 16 | Counter value |
| dir_down | output | 1 | High while counting down |
| zero_evt | output | 1 | One-clock strobe on reaching 0 |
| period_evt | output | 1 | One-clock strobe on reaching the period |

## Verification
A corrupted working period or mode stays hidden until the counter passes the boundary it governs. The bench therefore changes the shadow inputs mid-cycle, then checks the turnaround value and dir_down at the tick where the old setting must still apply and again at the first tick after zero. A bad divider or direction bit shows in count within one cycle of counting. Strobe faults are caught by counting pulse widths under a slow prescaler, where a level signal instead of a one-clock strobe would be high for several clocks.

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int PSC_W = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PSC_W-1:0] prescale,
  input  logic [CNT_W-1:0] period_in,
  input  logic [1:0]       mode_in,
  input  logic             sync,
  input  logic [CNT_W-1:0] phase,
  output logic [CNT_W-1:0] count,
  output logic             dir_down,
  output logic             zero_evt,
  output logic             period_evt
);
  localparam logic [1:0] M_DOWN = 2'd1;
  localparam logic [1:0] M_UPDN = 2'd2;

  logic [PSC_W-1:0] pcnt;
  logic [CNT_W-1:0] act_per, nxt;
  logic [1:0]       act_mode;
  logic             nxt_dir;

  wire             at_zero  = (count == '0);
  wire [CNT_W-1:0] eff_per  = at_zero ? period_in : act_per;
  wire [1:0]       eff_mode = at_zero ? mode_in : act_mode;
  wire             tick     = run && (pcnt >= prescale);

  always_comb begin
    nxt     = count;
    nxt_dir = dir_down;
    case (eff_mode)
      M_DOWN: begin
        nxt_dir = 1'b1;
        nxt     = (at_zero || count > eff_per) ? eff_per : count - 1'b1;
      end
      M_UPDN: begin
        if (!dir_down) begin
          if (count >= eff_per) begin
            nxt_dir = (eff_per != '0);
            nxt     = at_zero ? count : count - 1'b1;
          end else begin
            nxt = count + 1'b1;
          end
        end else if (at_zero) begin
          nxt_dir = 1'b0;
          nxt     = (eff_per == '0) ? '0 : CNT_W'(1);
        end else begin
          nxt = count - 1'b1;
        end
      end
      default: begin
        nxt_dir = 1'b0;
        nxt     = (count >= eff_per) ? '0 : count + 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcnt       <= '0;
      count      <= '0;
      dir_down   <= 1'b0;
      act_per    <= '0;
      act_mode   <= '0;
      zero_evt   <= 1'b0;
      period_evt <= 1'b0;
    end else begin
      zero_evt   <= 1'b0;
      period_evt <= 1'b0;
      if (at_zero) begin
        act_per  <= period_in;
        act_mode <= mode_in;
      end
      if (sync) begin
        count <= phase;
        pcnt  <= '0;
      end else if (tick) begin
        count      <= nxt;
        dir_down   <= nxt_dir;
        pcnt       <= '0;
        zero_evt   <= (nxt == '0);
        period_evt <= (nxt == eff_per);
      end else begin
        pcnt <= run ? pcnt + 1'b1 : '0;
      end
    end
  end

  a_r1_psc_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && prescale != '0) |=> (!tick || prescale == '0));
  a_r2_up_dir: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !sync && eff_mode != M_DOWN && eff_mode != M_UPDN) |=> !dir_down);
  a_r3_down_dir: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !sync && eff_mode == M_DOWN) |=> dir_down);
  a_r7_sync_load: assert property (@(posedge clk) disable iff (!rst_n)
    sync |=> (count == $past(phase)));
  a_r8_sync_dir: assert property (@(posedge clk) disable iff (!rst_n)
    sync |=> $stable(dir_down));
  a_r9_zero_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    zero_evt |-> (count == '0));
  a_r10_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!zero_evt && !period_evt));
  a_r10_stop_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !sync) |=> $stable(count));
endmodule

// File: tb/test_pwm_timebase.sv
module test_pwm_timebase;
  logic        clk = 1'b0;
  logic        rst_n, run, sync;
  logic [7:0]  prescale;
  logic [15:0] period_in, phase, count;
  logic [1:0]  mode_in;
  logic        dir_down, zero_evt, period_evt;
  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  pwm_timebase i_pwm_timebase (
    .clk(clk), .rst_n(rst_n), .run(run), .prescale(prescale),
    .period_in(period_in), .mode_in(mode_in), .sync(sync), .phase(phase),
    .count(count), .dir_down(dir_down), .zero_evt(zero_evt), .period_evt(period_evt)
  );

  // {mode, period, prescale, clocks, expected count, expected dir}
  localparam int NV = 9;
  localparam logic [50:0] VEC [NV] = '{
    {2'd0, 16'd4, 8'd0, 8'd7, 16'd2, 1'b0},
    {2'd1, 16'd4, 8'd0, 8'd3, 16'd2, 1'b1},
    {2'd2, 16'd3, 8'd0, 8'd5, 16'd1, 1'b1},
    {2'd2, 16'd3, 8'd0, 8'd6, 16'd0, 1'b1},
    {2'd2, 16'd3, 8'd0, 8'd7, 16'd1, 1'b0},
    {2'd0, 16'd5, 8'd2, 8'd9, 16'd3, 1'b0},
    {2'd0, 16'd0, 8'd0, 8'd5, 16'd0, 1'b0},
    {2'd1, 16'd2, 8'd1, 8'd8, 16'd2, 1'b1},
    {2'd3, 16'd2, 8'd0, 8'd4, 16'd1, 1'b0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setup(input logic [1:0] m, input logic [15:0] p, input logic [7:0] ps);
    @(negedge clk);
    rst_n = 1'b0; run = 1'b0; sync = 1'b0;
    mode_in = m; period_in = p; prescale = ps; phase = '0;
    wait_clk(2);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int zc, pc;
    string tag;
    rst_n = 1'b0; run = 1'b0; sync = 1'b0;
    mode_in = '0; period_in = '0; prescale = '0; phase = '0;
    wait_clk(3);
    chk("R11 count", int'(count), 0);
    chk("R11 dir", int'(dir_down), 0);
    chk("R11 strobes", int'({zero_evt, period_evt}), 0);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      setup(VEC[v][50:49], VEC[v][48:33], VEC[v][32:25]);
      case (VEC[v][50:49])
        2'd1: tag = "R3";
        2'd2: tag = "R4";
        default: tag = (VEC[v][48:33] == 0) ? "R5" : "R2";
      endcase
      if (VEC[v][32:25] != 0) tag = {tag, "/R1"};
      run = 1'b1;
      wait_clk(int'(VEC[v][24:17]));
      chk({tag, " count"}, int'(count), int'(VEC[v][16:1]));
      chk({tag, " dir"}, int'(dir_down), int'(VEC[v][0]));
      run = 1'b0;
    end

    // R9: one-clock strobes under a slow prescaler
    setup(2'd0, 16'd3, 8'd3);
    run = 1'b1; zc = 0; pc = 0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      zc += int'(zero_evt); pc += int'(period_evt);
    end
    chk("R9 zero strobe width", zc, 1);
    chk("R9 period strobe width", pc, 1);
    chk("R9 count at wrap", int'(count), 0);
    wait_clk(8);
    chk("R1 count after restart", int'(count), 2);

    // R10: stop holds and stays quiet
    run = 1'b0; zc = 0; pc = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      zc += int'(zero_evt); pc += int'(period_evt);
    end
    chk("R10 hold count", int'(count), 2);
    chk("R10 no strobes", zc + pc, 0);

    // R6: period change mid-cycle waits for zero
    setup(2'd0, 16'd5, 8'd0);
    run = 1'b1;
    wait_clk(2);
    period_in = 16'd2;
    wait_clk(3);
    chk("R6 old period kept", int'(count), 5);
    wait_clk(3);
    chk("R6 new period count", int'(count), 2);
    wait_clk(1);
    chk("R6 new period wrap", int'(count), 0);

    // R6: mode change mid-cycle waits for zero
    setup(2'd0, 16'd3, 8'd0);
    run = 1'b1;
    wait_clk(1);
    mode_in = 2'd1;
    wait_clk(2);
    chk("R6 old mode count", int'(count), 3);
    chk("R6 old mode dir", int'(dir_down), 0);
    wait_clk(2);
    chk("R6 new mode count", int'(count), 3);
    chk("R6 new mode dir", int'(dir_down), 1);

    // R7: sync loads phase over a tick, and while stopped
    setup(2'd0, 16'd9, 8'd0);
    run = 1'b1;
    wait_clk(3);
    phase = 16'd7; sync = 1'b1;
    wait_clk(1);
    sync = 1'b0;
    chk("R7 sync load", int'(count), 7);
    wait_clk(1);
    chk("R7 count after sync", int'(count), 8);
    run = 1'b0; phase = 16'd1; sync = 1'b1;
    wait_clk(1);
    sync = 1'b0;
    chk("R7 sync while stopped", int'(count), 1);

    // R8: sync in up-down keeps direction
    setup(2'd2, 16'd6, 8'd0);
    run = 1'b1;
    wait_clk(8);
    chk("R4 falling count", int'(count), 4);
    phase = 16'd2; sync = 1'b1;
    wait_clk(1);
    sync = 1'b0;
    chk("R8 count", int'(count), 2);
    chk("R8 dir kept", int'(dir_down), 1);
    wait_clk(1);
    chk("R8 continues down", int'(count), 1);

    // R11: reset while running
    rst_n = 1'b0;
    wait_clk(1);
    chk("R11 mid-run count", int'(count), 0);
    chk("R11 mid-run dir", int'(dir_down), 0);
    rst_n = 1'b1; run = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule